// File: doc/BRIEF.md
# Sample-Playback Pulse-Width Modulator

This block plays back a stream of 8-bit samples as a pulse-width modulated output, for tones or low-rate voice. Software writes 16-bit words to a sample register. Each word becomes two sample bytes in a small byte FIFO: the high byte goes in first, then the low byte. An 8-bit period counter runs from a prescaled clock, and each period lasts 256 counts. At every period wrap the next byte leaves the FIFO and becomes the duty compare value. The output is high while the counter is below that value.

A control register selects the count source. The source is either the system clock or the rising edges of a low-frequency clock input in the 32 kHz class, which is brought into the system clock domain by a synchronizer. The same register holds a 7-bit prescaler, the module enable, a FIFO-room flag, an interrupt request bit and the interrupt enable. The request bit is raised when the FIFO runs down to one byte or none. Reading the control register clears it. Software can also set the bit directly, to test the interrupt path. There is one register port, one interrupt line and one output pin.

Top module: `smp_pwm`

## Requirements
- R1: After reset the control register reads 0x0020, irq_o is 0 and pwm_o is 0.
- R2: addr_i=0 selects the control register and addr_i=1 the sample register. The control register fields are: bit 15 source select (0 = system clock, 1 = lf_clk_i), bits 14:8 prescaler, bit 7 interrupt request, bit 6 interrupt enable, bit 5 FIFO room (read-only), bit 4 enable, and bits 3:0 read 0. A read of the sample register returns 0.
- R3: While enabled, one output period lasts 256*(P+1) source ticks and the output is high for S*(P+1) ticks, where P is the prescaler and S is the current sample byte.
- R4: A sample-register write puts bits 15:8 into the FIFO first and bits 7:0 second, and the bytes are played in FIFO order, one per period.
- R5: The FIFO holds DEPTH bytes (4 by default). A sample write is dropped when fewer than two bytes are free. Bit 5 reads 1 exactly when at least two bytes are free.
- R6: When the FIFO is empty at a period wrap, the previous sample is played again.
- R7: The request bit is set at any period wrap that takes a byte from the FIFO and leaves one byte or none. It is set whether or not interrupts are enabled. irq_o is high only while both the request bit and the enable bit are 1.
- R8: A read of the control register clears the request bit. A new request in the same cycle takes priority over the clear.
- R9: Writing 1 to bit 7 sets the request bit. Writing 0 to bit 7 leaves it unchanged.
- R10: A control write that clears the enable while it is set empties the FIFO. While disabled, the counters are held at zero and pwm_o is 0. Sample writes are still accepted while disabled.
- R11: With source select 1, one source tick is one synchronized rising edge of lf_clk_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lf_clk_i | input | 1 | Low-frequency clock, asynchronous to clk_i |
| req_i | input | 1 | Register access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 1 | 0 = control, 1 = sample |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid in the strobe cycle |
| irq_o | output | 1 | Interrupt request line |
| pwm_o | output | 1 | Modulated output |

## Verification
The bench uses the defaults DEPTH=4 and SYNC_STAGES=2. With them, two word writes fill the FIFO, so a third write lands on the "no room" boundary at once. The third pop of a run crosses the one-byte-left threshold, and the fifth period is already a replay. Prescaler values 0, 2 and 5 and an lf_clk_i edge every eight system clocks scale the period measurably while keeping each run to a few thousand cycles. Random sample bytes go from 1 to 255, so every period shows a rising edge that can be timed.

// File: rtl/smp_pwm_pkg.sv
package smp_pwm_pkg;
  localparam int SMP_W   = 8;
  localparam int PRESC_W = 7;
  localparam int WORD_W  = 2 * SMP_W;

  typedef struct packed {
    logic               lf_sel;
    logic [PRESC_W-1:0] presc;
    logic               irq;
    logic               irq_en;
    logic               room;
    logic               en;
    logic [3:0]         zero;
  } ctrl_t;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_SMP  = 1'b1;
endpackage

// File: rtl/smp_pwm_fifo.sv
module smp_pwm_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push2_i,
  input  logic [DW-1:0] first_i,
  input  logic [DW-1:0] second_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          room2_o
);
  // DEPTH must be a power of two, >= 2: pointers wrap by overflow
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign empty_o = (cnt_q == '0);
  assign room2_o = (cnt_q <= CW'(DEPTH - 2));
  assign push_ok = push2_i & room2_o & ~flush_i;
  assign pop_ok  = pop_i & ~empty_o & ~flush_i;
  assign head_o  = mem_q[rptr_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wptr_q <= wptr_q + PW'(2);
      if (pop_ok)  rptr_q <= rptr_q + PW'(1);
      cnt_q <= cnt_q + (push_ok ? CW'(2) : CW'(0)) - (pop_ok ? CW'(1) : CW'(0));
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) begin
      mem_q[wptr_q]          <= first_i;
      mem_q[wptr_q + PW'(1)] <= second_i;
    end
  end
endmodule

// File: rtl/smp_pwm_tick.sv
module smp_pwm_tick #(
  parameter int PW   = 7,
  parameter int SYNC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          lf_sel_i,
  input  logic          lf_clk_i,
  input  logic [PW-1:0] presc_i,
  output logic          tick_o
);
  logic [SYNC-1:0] sync_q;
  logic            prev_q;
  logic            lf_rise, src;
  logic [PW-1:0]   pcnt_q;

  generate
    if (SYNC == 1) begin : g_sync1
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= lf_clk_i;
      end
    end else begin : g_syncn
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC-2:0], lf_clk_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[SYNC-1];
  end

  assign lf_rise = sync_q[SYNC-1] & ~prev_q;
  assign src     = lf_sel_i ? lf_rise : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pcnt_q <= '0;
    else if (!en_i)              pcnt_q <= '0;
    else if (src) begin
      if (pcnt_q == presc_i)     pcnt_q <= '0;
      else                       pcnt_q <= pcnt_q + PW'(1);
    end
  end

  assign tick_o = en_i & src & (pcnt_q == presc_i);
endmodule

// File: rtl/smp_pwm_core.sv
module smp_pwm_core #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          empty_i,
  input  logic [DW-1:0] head_i,
  output logic          wrap_o,
  output logic          pop_o,
  output logic [DW-1:0] cmp_o,
  output logic          pwm_o
);
  logic [DW-1:0] cnt_q, cmp_q;

  assign wrap_o = en_i & tick_i & (cnt_q == '1);
  assign pop_o  = wrap_o & ~empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + DW'(1);
  end

  // empty at wrap: cmp_q keeps the last sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmp_q <= '0;
    else if (!en_i)  cmp_q <= '0;
    else if (pop_o)  cmp_q <= head_i;
  end

  assign cmp_o = cmp_q;
  assign pwm_o = en_i & (cnt_q < cmp_q);
endmodule

// File: rtl/smp_pwm.sv
module smp_pwm
  import smp_pwm_pkg::*;
#(
  parameter int DEPTH       = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CW         = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lf_clk_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              pwm_o
);
  ctrl_t          wr_c, rd_c;
  logic           lf_sel_q, irq_en_q, en_q, irq_q;
  logic [PRESC_W-1:0] presc_q;
  logic           ctrl_wr, ctrl_rd, smp_wr, flush;
  logic           tick, wrap, pop, empty, room2, irq_set;
  logic [SMP_W-1:0] head, cmp;
  logic [CW-1:0]  count;

  assign wr_c    = ctrl_t'(wdata_i);
  assign ctrl_wr = req_i & we_i  & (addr_i == ADDR_CTRL);
  assign ctrl_rd = req_i & ~we_i & (addr_i == ADDR_CTRL);
  assign smp_wr  = req_i & we_i  & (addr_i == ADDR_SMP);
  assign flush   = ctrl_wr & en_q & ~wr_c.en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lf_sel_q <= 1'b0;
      presc_q  <= '0;
      irq_en_q <= 1'b0;
      en_q     <= 1'b0;
    end else if (ctrl_wr) begin
      lf_sel_q <= wr_c.lf_sel;
      presc_q  <= wr_c.presc;
      irq_en_q <= wr_c.irq_en;
      en_q     <= wr_c.en;
    end
  end

  // a pop that leaves <= 1 byte raises the request
  assign irq_set = pop & (count <= CW'(2));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        irq_q <= 1'b0;
    else if (irq_set)                   irq_q <= 1'b1;
    else if (ctrl_wr && wr_c.irq)       irq_q <= 1'b1;
    else if (ctrl_rd)                   irq_q <= 1'b0;
  end

  always_comb begin
    rd_c        = '0;
    rd_c.lf_sel = lf_sel_q;
    rd_c.presc  = presc_q;
    rd_c.irq    = irq_q;
    rd_c.irq_en = irq_en_q;
    rd_c.room   = room2;
    rd_c.en     = en_q;
    rdata_o     = ctrl_rd ? WORD_W'(rd_c) : '0;
  end

  assign irq_o = irq_q & irq_en_q;

  smp_pwm_tick #(.PW(PRESC_W), .SYNC(SYNC_STAGES)) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_q),
    .lf_sel_i (lf_sel_q),
    .lf_clk_i (lf_clk_i),
    .presc_i  (presc_q),
    .tick_o   (tick)
  );

  smp_pwm_fifo #(.DW(SMP_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (flush),
    .push2_i  (smp_wr),
    .first_i  (wdata_i[WORD_W-1:SMP_W]),
    .second_i (wdata_i[SMP_W-1:0]),
    .pop_i    (pop),
    .head_o   (head),
    .count_o  (count),
    .empty_o  (empty),
    .room2_o  (room2)
  );

  smp_pwm_core #(.DW(SMP_W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_q),
    .tick_i  (tick),
    .empty_i (empty),
    .head_i  (head),
    .wrap_o  (wrap),
    .pop_o   (pop),
    .cmp_o   (cmp),
    .pwm_o   (pwm_o)
  );
endmodule

// File: rtl/smp_pwm_chk.sv
module smp_pwm_chk #(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          we_i,
  input logic          addr_i,
  input logic [15:0]   rdata_o,
  input logic          irq_o,
  input logic          pwm_o,
  input logic          en_q,
  input logic          irq_q,
  input logic          irq_set,
  input logic          wrap,
  input logic          pop,
  input logic          empty,
  input logic [CW-1:0] count,
  input logic [7:0]    head,
  input logic [7:0]    cmp
);
  // R10
  off_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !pwm_o);
  // R5
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= CW'(DEPTH));
  // R5
  room_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == 1'b0) |-> (rdata_o[5] == (count <= CW'(DEPTH - 2))));
  // R4
  pop_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop |=> (cmp == $past(head) || !en_q));
  // R6
  replay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && empty) |=> ($stable(cmp) || !en_q));
  // R7
  irq_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_set |=> irq_q);
  // R8
  read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == 1'b0 && !irq_set) |=> !irq_q);
  // R7
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_q);
endmodule

bind smp_pwm smp_pwm_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .pwm_o   (pwm_o),
  .en_q    (en_q),
  .irq_q   (irq_q),
  .irq_set (irq_set),
  .wrap    (wrap),
  .pop     (pop),
  .empty   (empty),
  .count   (count),
  .head    (head),
  .cmp     (cmp)
);

// File: tb/smp_pwm_bench.sv
`timescale 1ns/1ps
module smp_pwm_bench;
  logic clk = 1'b0, rst_n = 1'b0, lf_clk = 1'b0;
  logic req = 1'b0, we = 1'b0, addr = 1'b0;
  logic [15:0] wdata = '0, rdata;
  logic irq, pwm;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  always #80 lf_clk = ~lf_clk;

  smp_pwm u_smp_pwm (
    .clk_i(clk), .rst_ni(rst_n), .lf_clk_i(lf_clk),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .pwm_o(pwm)
  );

  // pulse monitor: high time and rise-to-rise period, sampled at negedge
  logic mon_rst = 1'b1;
  int hi_arr [8];
  int per_arr [8];
  int npulse, since_rise, hi_cnt;
  logic prev;
  always @(negedge clk) begin
    if (mon_rst) begin
      npulse = 0; since_rise = 0; hi_cnt = 0; prev = 1'b0;
    end else begin
      if (pwm && !prev) begin
        if (npulse > 0 && npulse <= 8) per_arr[npulse-1] = since_rise;
        since_rise = 1; hi_cnt = 1; npulse++;
      end else begin
        since_rise++;
        if (pwm) hi_cnt++;
      end
      if (!pwm && prev && npulse > 0 && npulse <= 8) hi_arr[npulse-1] = hi_cnt;
      prev = pwm;
    end
  end

  function automatic logic [15:0] mk_ctrl(input logic src, input logic [6:0] p,
                                          input logic irqb, input logic ie, input logic en);
    return {src, p, irqb, ie, 1'b0, en, 4'b0000};
  endfunction

  function automatic int exp_hi(input int s, input int unit);
    return s * unit;
  endfunction

  function automatic int exp_per(input int unit);
    return 256 * unit;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic wait_pulses(input int n);
    while (npulse < n) @(negedge clk);
  endtask

  task automatic play(input logic src, input logic [6:0] p, input logic ie);
    logic [7:0] b [4];
    logic [15:0] r;
    int unit;
    for (int i = 0; i < 4; i++) b[i] = 8'($urandom_range(255, 1));
    unit = (int'(p) + 1) * (src ? 8 : 1);
    wr(0, mk_ctrl(src, p, 1'b0, ie, 1'b0));
    wr(1, {b[0], b[1]});
    wr(1, {b[2], b[3]});
    rd(0, r);
    chk("R5 room flag full", int'(r[5]), 0);
    wr(1, {~b[3] | 8'h01, 8'h01});  // R5: dropped, FIFO full
    mon_rst = 1'b1;
    @(negedge clk); mon_rst = 1'b0;
    wr(0, mk_ctrl(src, p, 1'b0, ie, 1'b1));
    wait_pulses(2);
    chk("R7 no irq at two left", int'(irq), 0);
    wait_pulses(3);
    chk("R7 irq line one left", int'(irq), int'(ie));
    rd(0, r);
    chk("R7 irq bit polled", int'(r[7]), 1);
    chk("R5 room flag one left", int'(r[5]), 1);
    chk("R8 cleared by read", int'(irq), 0);
    rd(0, r);
    chk("R8 bit reads 0", int'(r[7]), 0);
    wait_pulses(4);
    chk("R7 irq line empty", int'(irq), int'(ie));
    rd(0, r);
    wait_pulses(7);
    for (int i = 0; i < 4; i++) chk("R4 R3 high time", hi_arr[i], exp_hi(int'(b[i]), unit));
    chk("R6 replay high time", hi_arr[4], exp_hi(int'(b[3]), unit));
    chk("R6 replay high time 2", hi_arr[5], exp_hi(int'(b[3]), unit));
    for (int i = 0; i < 6; i++) chk(src ? "R11 lf period" : "R3 period", per_arr[i], exp_per(unit));
    chk("R7 no irq on empty wrap", int'(irq), 0);
    wr(0, mk_ctrl(src, p, 1'b0, ie, 1'b0));
    chk("R10 low after disable", int'(pwm), 0);
  endtask

  initial begin : main
    logic [15:0] r;
    int bad;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1 irq_o reset", int'(irq), 0);
    chk("R1 pwm_o reset", int'(pwm), 0);
    rst_n = 1'b1;
    rd(0, r);
    chk("R1 ctrl reset value", int'(r), 32'h0020);

    // R2 field placement
    wr(0, mk_ctrl(1'b1, 7'h5A, 1'b0, 1'b1, 1'b0));
    rd(0, r);
    chk("R2 ctrl fields", int'(r), 32'hDA60);
    rd(1, r);
    chk("R2 sample read zero", int'(r), 0);

    // R9 software request
    wr(0, mk_ctrl(1'b0, 7'd0, 1'b1, 1'b1, 1'b0));
    chk("R9 forced irq", int'(irq), 1);
    wr(0, mk_ctrl(1'b0, 7'd0, 1'b0, 1'b1, 1'b0));
    chk("R9 write 0 keeps", int'(irq), 1);
    rd(0, r);
    chk("R9 bit set", int'(r[7]), 1);
    chk("R8 clear after read", int'(irq), 0);

    play(1'b0, 7'd0, 1'b1);
    play(1'b0, 7'd2, 1'b0);  // R7 gating: line stays low
    play(1'b0, 7'(5), 1'b1);
    play(1'b1, 7'd0, 1'b1);  // R11

    // R10 flush on disable
    wr(0, mk_ctrl(1'b0, 7'd0, 1'b0, 1'b0, 1'b0));
    wr(1, 16'h8040);
    wr(1, 16'h20F0);
    mon_rst = 1'b1;
    @(negedge clk); mon_rst = 1'b0;
    wr(0, mk_ctrl(1'b0, 7'd0, 1'b0, 1'b0, 1'b1));
    wait_pulses(1);
    wr(0, mk_ctrl(1'b0, 7'd0, 1'b0, 1'b0, 1'b0));
    bad = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (pwm) bad++;
    end
    chk("R10 output held low", bad, 0);
    rd(0, r);
    chk("R10 fifo flushed", int'(r[5]), 1);
    chk("R10 enable off", int'(r[4]), 0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule